// File: doc/BRIEF.md
# Burst Transfer Protocol Monitor

This block passively observes the master side of a pipelined system bus that marks each transfer with a 3-bit cycle-type code. It keeps separate running totals of single writes, single reads, completed write bursts and completed read bursts. It also checks that every incrementing burst has exactly the configured number of beats. When a transfer breaks the sequencing rules, the block latches an error flag and a 2-bit cause code. Both stay set until software pulses a clear input.

Only cycles in which the cycle-valid line and the acknowledge line are both high are evaluated. An internal beat counter tracks how many incrementing beats of the current burst have been acknowledged. The counter returns to zero when a burst ends legally and whenever a fault is detected, so the monitor resynchronises on the next transfer. The 2-bit burst-extension field seen on the final beat of each legal burst is recorded as-is. All outputs are registered and show the effect of an acknowledged beat one clock after it.

Top module: `bus_burst_monitor`

## Requirements
- R1: After reset, all four counters, `last_burst_bte`, `err` and `err_code` are zero.
- R2: A clock edge where `cyc` or `ack` is low changes no counter and raises no error, whatever `cti`, `we` and `bte` carry.
- R3: An acknowledged `cti` = 3'b000 with the beat count at zero adds one to `single_wr_cnt` when `we` = 1, or to `single_rd_cnt` when `we` = 0, visible one clock later.
- R4: Exactly BURST_LEN-1 acknowledged `cti` = 3'b010 beats followed by an acknowledged `cti` = 3'b111 beat adds one to `burst_wr_cnt` or `burst_rd_cnt`, chosen by `we` on that final beat. It also copies that beat's `bte` into `last_burst_bte`.
- R5: An acknowledged `cti` = 3'b000 while the beat count is nonzero is a fault with cause 2'b01. It is not counted as a single transfer.
- R6: An acknowledged `cti` = 3'b111 after fewer than BURST_LEN-1 incrementing beats is a fault with cause 2'b10. An acknowledged `cti` = 3'b010 when BURST_LEN-1 incrementing beats are already counted is also a fault with cause 2'b10.
- R7: An acknowledged `cti` other than 3'b000, 3'b010 and 3'b111 is a fault with cause 2'b11.
- R8: After a legal burst end or any fault, the beat count is zero, so the next transfer is judged as the start of a new sequence.
- R9: `err` stays high and `err_code` keeps the cause of the first fault until `clr_err` is high at a clock edge. A clear with no fault at the same edge gives `err` = 0 and `err_code` = 2'b00. A fault at the same edge as a clear is captured.
- R10: Each counter is CNT_W bits wide and wraps to zero after its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc | input | 1 | Bus cycle valid from the master |
| we | input | 1 | Write enable from the master |
| ack | input | 1 | Acknowledge from the slave |
| cti | input | 3 | Cycle-type code of the current beat |
| bte | input | 2 | Burst extension field, recorded only |
| clr_err | input | 1 | Clears the sticky error |
| single_wr_cnt | output | CNT_W | Count of single writes |
| single_rd_cnt | output | CNT_W | Count of single reads |
| burst_wr_cnt | output | CNT_W | Count of completed write bursts |
| burst_rd_cnt | output | CNT_W | Count of completed read bursts |
| last_burst_bte | output | 2 | Extension field of the latest legal burst end |
| err | output | 1 | Sticky fault flag |
| err_code | output | 2 | Cause of the latched fault |

## Verification
The bench builds the monitor with BURST_LEN = 3 and CNT_W = 8. A burst length that is not a power of two leaves beat-counter codes unused, so an over-long burst has to be caught by comparison and cannot rely on natural overflow. Eight-bit counters let a directed run of a few hundred single reads reach the wrap-around. The random phase mixes short, exact and long bursts with stray singles and unknown codes.

// File: rtl/bmon_pkg.sv
package bmon_pkg;

  localparam logic [2:0] CTI_CLASSIC = 3'b000;
  localparam logic [2:0] CTI_INCR    = 3'b010;
  localparam logic [2:0] CTI_END     = 3'b111;

  typedef enum logic [1:0] {
    FAULT_NONE     = 2'b00,
    FAULT_IN_BURST = 2'b01,
    FAULT_LENGTH   = 2'b10,
    FAULT_UNKNOWN  = 2'b11
  } fault_e;

  typedef struct packed {
    logic   single;
    logic   step;
    logic   done;
    logic   fault;
    fault_e kind;
  } beat_event_t;

endpackage

// File: rtl/bmon_classify.sv
module bmon_classify
  import bmon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int BEAT_W    = 2
) (
  input  logic              valid,
  input  logic [2:0]        cti,
  input  logic [BEAT_W-1:0] beats,
  output beat_event_t       ev
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

  always_comb begin
    ev.single = 1'b0;
    ev.step   = 1'b0;
    ev.done   = 1'b0;
    ev.fault  = 1'b0;
    ev.kind   = FAULT_NONE;
    if (valid) begin
      case (cti)
        CTI_CLASSIC: begin
          if (beats != '0) begin
            ev.fault = 1'b1;
            ev.kind  = FAULT_IN_BURST;
          end else begin
            ev.single = 1'b1;
          end
        end
        CTI_INCR: begin
          if (beats == LAST_BEAT) begin
            ev.fault = 1'b1;
            ev.kind  = FAULT_LENGTH;
          end else begin
            ev.step = 1'b1;
          end
        end
        CTI_END: begin
          if (beats == LAST_BEAT) begin
            ev.done = 1'b1;
          end else begin
            ev.fault = 1'b1;
            ev.kind  = FAULT_LENGTH;
          end
        end
        default: begin
          ev.fault = 1'b1;
          ev.kind  = FAULT_UNKNOWN;
        end
      endcase
    end
  end

endmodule

// File: rtl/bmon_beat_tracker.sv
module bmon_beat_tracker #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              restart,
  output logic [BEAT_W-1:0] beats
);

  always_ff @(posedge clk) begin
    if (rst) begin
      beats <= '0;
    end else if (step) begin
      beats <= beats + 1'b1;
    end else if (restart) begin
      beats <= '0;
    end
  end

endmodule

// File: rtl/bmon_tally.sv
module bmon_tally #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (inc) begin
      value <= value + 1'b1;
    end
  end

endmodule

// File: rtl/bmon_err_latch.sv
module bmon_err_latch
  import bmon_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   fault,
  input  fault_e kind,
  input  logic   clr,
  output logic   err,
  output fault_e code
);

  always_ff @(posedge clk) begin
    if (rst) begin
      err  <= 1'b0;
      code <= FAULT_NONE;
    end else if (fault && (!err || clr)) begin
      err  <= 1'b1;
      code <= kind;
    end else if (clr) begin
      err  <= 1'b0;
      code <= FAULT_NONE;
    end
  end

endmodule

// File: rtl/bus_burst_monitor.sv
module bus_burst_monitor
  import bmon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc,
  input  logic             we,
  input  logic             ack,
  input  logic [2:0]       cti,
  input  logic [1:0]       bte,
  input  logic             clr_err,
  output logic [CNT_W-1:0] single_wr_cnt,
  output logic [CNT_W-1:0] single_rd_cnt,
  output logic [CNT_W-1:0] burst_wr_cnt,
  output logic [CNT_W-1:0] burst_rd_cnt,
  output logic [1:0]       last_burst_bte,
  output logic             err,
  output logic [1:0]       err_code
);

  localparam int BEAT_W  = (BURST_LEN > 2) ? $clog2(BURST_LEN) : 1;
  localparam int TALLY_N = 4;
  localparam int IDX_SWR = 0;
  localparam int IDX_SRD = 1;
  localparam int IDX_BWR = 2;
  localparam int IDX_BRD = 3;

  logic              beat_valid;
  logic [BEAT_W-1:0] beats;
  beat_event_t       ev;
  logic [TALLY_N-1:0] tally_inc;
  logic [CNT_W-1:0]  tally_q [TALLY_N];
  fault_e            code_q;

  assign beat_valid = cyc & ack;

  bmon_classify #(
    .BURST_LEN(BURST_LEN),
    .BEAT_W   (BEAT_W)
  ) u_classify (
    .valid(beat_valid),
    .cti  (cti),
    .beats(beats),
    .ev   (ev)
  );

  bmon_beat_tracker #(
    .BEAT_W(BEAT_W)
  ) u_beats (
    .clk    (clk),
    .rst    (rst),
    .step   (ev.step),
    .restart(ev.done | ev.fault),
    .beats  (beats)
  );

  always_comb begin
    tally_inc          = '0;
    tally_inc[IDX_SWR] = ev.single &  we;
    tally_inc[IDX_SRD] = ev.single & ~we;
    tally_inc[IDX_BWR] = ev.done   &  we;
    tally_inc[IDX_BRD] = ev.done   & ~we;
  end

  for (genvar g = 0; g < TALLY_N; g++) begin : g_tally
    bmon_tally #(
      .W(CNT_W)
    ) u_tally (
      .clk  (clk),
      .rst  (rst),
      .inc  (tally_inc[g]),
      .value(tally_q[g])
    );
  end

  assign single_wr_cnt = tally_q[IDX_SWR];
  assign single_rd_cnt = tally_q[IDX_SRD];
  assign burst_wr_cnt  = tally_q[IDX_BWR];
  assign burst_rd_cnt  = tally_q[IDX_BRD];

  always_ff @(posedge clk) begin
    if (rst) begin
      last_burst_bte <= 2'b00;
    end else if (ev.done) begin
      last_burst_bte <= bte;
    end
  end

  bmon_err_latch u_err (
    .clk  (clk),
    .rst  (rst),
    .fault(ev.fault),
    .kind (ev.kind),
    .clr  (clr_err),
    .err  (err),
    .code (code_q)
  );

  assign err_code = code_q;

endmodule

// File: rtl/bmon_checker.sv
module bmon_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc,
  input logic             we,
  input logic             ack,
  input logic [2:0]       cti,
  input logic             clr_err,
  input logic [CNT_W-1:0] single_wr_cnt,
  input logic [CNT_W-1:0] single_rd_cnt,
  input logic [CNT_W-1:0] burst_wr_cnt,
  input logic [CNT_W-1:0] burst_rd_cnt,
  input logic             err,
  input logic [1:0]       err_code
);

  logic beat_seen;
  logic cti_legal;
  assign beat_seen = cyc && ack;
  assign cti_legal = (cti == 3'b000) || (cti == 3'b010) || (cti == 3'b111);

  assert_idle_no_effect_R2: assert property (@(posedge clk) disable iff (rst)
    !beat_seen |=> ($stable(single_wr_cnt) && $stable(single_rd_cnt) &&
                    $stable(burst_wr_cnt) && $stable(burst_rd_cnt) && !$rose(err)));

  assert_single_wr_source_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(single_wr_cnt) |-> $past(beat_seen && we && cti == 3'b000));

  assert_burst_rd_source_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(burst_rd_cnt) |-> $past(beat_seen && !we && cti == 3'b111));

  assert_burst_wr_source_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(burst_wr_cnt) |-> $past(beat_seen && we && cti == 3'b111));

  assert_unknown_code_R7: assert property (@(posedge clk) disable iff (rst)
    (beat_seen && !cti_legal && (!err || clr_err)) |=> (err && err_code == 2'b11));

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (err && !clr_err) |=> (err && $stable(err_code)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !beat_seen) |=> (!err && err_code == 2'b00));

endmodule

bind bus_burst_monitor bmon_checker #(.CNT_W(CNT_W)) u_bmon_chk (
  .clk          (clk),
  .rst          (rst),
  .cyc          (cyc),
  .we           (we),
  .ack          (ack),
  .cti          (cti),
  .clr_err      (clr_err),
  .single_wr_cnt(single_wr_cnt),
  .single_rd_cnt(single_rd_cnt),
  .burst_wr_cnt (burst_wr_cnt),
  .burst_rd_cnt (burst_rd_cnt),
  .err          (err),
  .err_code     (err_code)
);

// File: tb/bus_burst_monitor_test.sv
`timescale 1ns/1ps
module bus_burst_monitor_test;

  localparam int BL = 3;
  localparam int CW = 8;
  localparam int CMASK = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cyc = 1'b0;
  logic          we  = 1'b0;
  logic          ack = 1'b0;
  logic [2:0]    cti = 3'b000;
  logic [1:0]    bte = 2'b00;
  logic          clr_err = 1'b0;
  logic [CW-1:0] single_wr_cnt, single_rd_cnt, burst_wr_cnt, burst_rd_cnt;
  logic [1:0]    last_burst_bte;
  logic          err;
  logic [1:0]    err_code;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  int m_beats = 0;
  int m_swr = 0, m_srd = 0, m_bwr = 0, m_brd = 0;
  int m_bte = 0;
  int m_err = 0;
  int m_code = 0;

  always #2 clk = ~clk;

  bus_burst_monitor #(.BURST_LEN(BL), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .cyc(cyc), .we(we), .ack(ack), .cti(cti), .bte(bte),
    .clr_err(clr_err), .single_wr_cnt(single_wr_cnt), .single_rd_cnt(single_rd_cnt),
    .burst_wr_cnt(burst_wr_cnt), .burst_rd_cnt(burst_rd_cnt),
    .last_burst_bte(last_burst_bte), .err(err), .err_code(err_code)
  );

  // fault cause for an acknowledged beat: 0 none, 1 single in burst, 2 length, 3 unknown
  function automatic int fault_of(int beats, int t);
    if (t == 0) return (beats != 0) ? 1 : 0;
    if (t == 2) return (beats == BL - 1) ? 2 : 0;
    if (t == 7) return (beats == BL - 1) ? 0 : 2;
    return 3;
  endfunction

  task automatic model(int c, int a, int w, int t, int b, int clr);
    int f;
    f = 0;
    if (c != 0 && a != 0) begin
      f = fault_of(m_beats, t);
      if (f != 0) begin
        m_beats = 0;
      end else if (t == 0) begin
        if (w != 0) m_swr = (m_swr + 1) & CMASK;
        else        m_srd = (m_srd + 1) & CMASK;
      end else if (t == 2) begin
        m_beats = m_beats + 1;
      end else begin
        if (w != 0) m_bwr = (m_bwr + 1) & CMASK;
        else        m_brd = (m_brd + 1) & CMASK;
        m_bte = b;
        m_beats = 0;
      end
    end
    if (f != 0 && (m_err == 0 || clr != 0)) begin
      m_err = 1; m_code = f;
    end else if (clr != 0) begin
      m_err = 0; m_code = 0;
    end
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    check(req, "single_wr_cnt", int'(single_wr_cnt), m_swr);
    check(req, "single_rd_cnt", int'(single_rd_cnt), m_srd);
    check(req, "burst_wr_cnt", int'(burst_wr_cnt), m_bwr);
    check(req, "burst_rd_cnt", int'(burst_rd_cnt), m_brd);
    check(req, "last_burst_bte", int'(last_burst_bte), m_bte);
    check(req, "err", int'(err), m_err);
    check(req, "err_code", int'(err_code), m_code);
  endtask

  // called at a falling edge; outputs are compared at the next falling edge
  task automatic step(int c, int a, int w, int t, int b, int clr, string req);
    cyc = c[0]; ack = a[0]; we = w[0]; cti = t[2:0]; bte = b[1:0]; clr_err = clr[0];
    @(posedge clk);
    @(negedge clk);
    model(c, a, w, t, b, clr);
    compare_all(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare_all("R1");

    step(1, 1, 1, 0, 0, 0, "R3");
    step(1, 1, 0, 0, 0, 0, "R3");
    step(1, 0, 1, 0, 0, 0, "R2");
    step(0, 1, 0, 7, 3, 0, "R2");
    step(0, 1, 1, 5, 0, 0, "R2");
    // legal write burst
    step(1, 1, 1, 2, 2, 0, "R4");
    step(1, 0, 1, 2, 2, 0, "R2");
    step(1, 1, 1, 2, 2, 0, "R4");
    step(1, 1, 1, 7, 2, 0, "R4");
    // legal read burst
    step(1, 1, 0, 2, 1, 0, "R4");
    step(1, 1, 0, 2, 1, 0, "R4");
    step(1, 1, 0, 7, 1, 0, "R4");
    // single inside burst
    step(1, 1, 1, 2, 0, 0, "R5");
    step(1, 1, 1, 0, 0, 0, "R5");
    // a second fault leaves the first cause
    step(1, 1, 1, 7, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, "R9");
    step(1, 1, 1, 0, 0, 0, "R8");
    // short burst
    step(1, 1, 0, 2, 0, 0, "R6");
    step(1, 1, 0, 7, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, "R9");
    // long burst
    step(1, 1, 1, 2, 0, 0, "R6");
    step(1, 1, 1, 2, 0, 0, "R6");
    step(1, 1, 1, 2, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 1, "R9");
    step(1, 1, 1, 2, 3, 0, "R8");
    step(1, 1, 1, 2, 3, 0, "R8");
    step(1, 1, 1, 7, 3, 0, "R8");
    // unknown code
    step(1, 1, 0, 5, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 1, "R9");
    step(1, 1, 0, 7, 0, 0, "R6");
    // fault together with clear replaces the latched cause
    step(1, 1, 0, 1, 0, 1, "R9");
    step(0, 0, 0, 0, 0, 1, "R9");
    // counter wrap
    for (int i = 0; i < 260; i++) step(1, 1, 0, 0, 0, 0, "R10");

    for (int i = 0; i < 3000; i++) begin
      int r, t, c, a, w, b, clr;
      r = int'($urandom % 20);
      if (r < 8)       t = 2;
      else if (r < 12) t = 7;
      else if (r < 17) t = 0;
      else begin
        int u;
        u = int'($urandom % 5);
        t = (u == 0) ? 1 : u + 2;
      end
      c   = (($urandom % 10) != 0) ? 1 : 0;
      a   = (($urandom % 5) != 0) ? 1 : 0;
      w   = int'($urandom % 2);
      b   = int'($urandom % 4);
      clr = (($urandom % 30) == 0) ? 1 : 0;
      step(c, a, w, t, b, clr, "R8 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule